// File: doc/BRIEF.md
# Master Clock Rate Detector, Tick Divider and Standby Sequencer

This block runs on the master clock. It counts master-clock cycles between rising edges of the frame sync. It matches that count against eight known frame lengths and, once a length has been confirmed, produces two pulses. The first is a one-cycle pulse at 32 times the frame rate, which is 256 kHz for an 8 kHz frame. The second is a one-cycle strobe once per frame, at the sample rate. The tick rate never changes with the master clock rate. A fractional accumulator spreads the 32 ticks evenly across frames whose length is not a multiple of 32 (193 and 600 cycles).

The same block owns the power state. It drops into standby in two cases: the power-up input is low, or no frame-sync edge arrives within one frame length plus a margin while the master clock keeps running. It leaves standby only when the power-up input is high and a frame-sync edge arrives. After waking, it withholds the serial-output permit for two further frames.

The downstream codec uses the two pulses as its internal time base. It uses the permit to decide when its transmit pin may leave high impedance.

Top module: `mclk_prescaler`

## Requirements
- R1: While reset is asserted and right after reset, `standby` is 1 and `tx_permit`, `tick_256k` and `tick_8k` are 0.
- R2: A measured frame length L (cycles between two sync rising edges) is matched to the nearest entry of the table {index 0:32, 1:64, 2:192, 3:193, 4:256, 5:320, 6:512, 7:600}, provided the distance is at most 1. The matched length becomes the active ratio only when two consecutive measured frames give the same table entry. A frame of 257 cycles therefore runs as 256.
- R3: A measured length more than 1 away from every table entry leaves the active ratio unchanged.
- R4: With the active length N, the ticks follow floor(32·k/N) counted from each sync edge. A steady frame of N cycles carries exactly 32 ticks. Tick spacing is floor(N/32) or ceil(N/32), and any window of f cycles under steady frames of length f carries floor(32·f/N)·(frames) ticks.
- R5: `tick_8k` is high only in a cycle where `tick_256k` is also high, and marks the 32nd tick after a sync edge, so a steady frame carries exactly one strobe.
- R6: When no sync rising edge arrives for more than N+8 cycles, `standby` rises. N is the active length, or 600 before any ratio is committed. `standby` stays 0 for at least N cycles after the last edge.
- R7: Within three cycles of `pwr_up` going low, `standby` is 1, and it stays 1 while `pwr_up` is low, even with frame sync running.
- R8: Standby is left only on a sync rising edge that arrives while `pwr_up` is high. `pwr_up` high without sync edges keeps `standby` at 1.
- R9: `tx_permit` is 0 in standby and rises at the second sync rising edge after the edge that ended standby.
- R10: `tick_256k` and `tick_8k` are 0 while in standby or while no ratio has yet been committed. The committed ratio is kept through standby, so ticks resume at once after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; its rising edge marks a frame start |
| pwr_up | input | 1 | Power-up request; low forces standby |
| tick_256k | output | 1 | One-cycle pulse, 32 per frame |
| tick_8k | output | 1 | One-cycle strobe on the 32nd tick of a frame |
| standby | output | 1 | Low-power state flag |
| tx_permit | output | 1 | Serial output may be driven |

## Verification
Several rules are checked on every cycle:
- the strobe coinciding with a tick;
- silence of ticks and permit in standby;
- ratio changes and standby exits happening only on a sync edge with the power request high;
- a timeout or a low power request leading to standby.

Only the bench scenarios can show the following:
- the tick counts and spacings for each of the eight frame lengths;
- nearest-entry matching for off-by-one lengths;
- an unknown length being ignored;
- the exact N+8 timeout window;
- the two-frame permit delay.

// File: rtl/mclk_prescaler_pkg.sv
package mclk_prescaler_pkg;
  localparam int LEN_W  = 10;
  localparam int RATE_N = 8;
  localparam int IDX_W  = $clog2(RATE_N);

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } class_t;

  // Frame length in master-clock cycles for each supported rate.
  function automatic len_t rate_len(input idx_t i);
    case (i)
      3'd0:    return len_t'(32);
      3'd1:    return len_t'(64);
      3'd2:    return len_t'(192);
      3'd3:    return len_t'(193);
      3'd4:    return len_t'(256);
      3'd5:    return len_t'(320);
      3'd6:    return len_t'(512);
      default: return len_t'(600);
    endcase
  endfunction

  // Nearest table entry within tol cycles; first entry wins on a tie.
  function automatic class_t classify(input len_t n, input int tol);
    class_t r;
    int best;
    int d;
    r = '0;
    best = tol + 1;
    for (int i = 0; i < RATE_N; i++) begin
      d = int'(n) - int'(rate_len(idx_t'(i)));
      if (d < 0) d = -d;
      if (d < best) begin
        best  = d;
        r.hit = 1'b1;
        r.idx = idx_t'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/mclk_frame_meter.sv
module mclk_frame_meter
  import mclk_prescaler_pkg::*;
#(
  parameter int MATCH_TOL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic fs_rise,
  output len_t cnt,
  output logic commit,
  output idx_t ratio_idx,
  output logic locked
);
  logic   fs_q, fs_qq, have_prev;
  logic   cand_valid;
  idx_t   cand_idx;
  len_t   meas;
  class_t cls;
  logic   meas_ok;

  assign fs_rise = fs_q & ~fs_qq;
  assign meas    = cnt + len_t'(1);
  assign cls     = classify(meas, MATCH_TOL);
  assign meas_ok = fs_rise & have_prev & cls.hit;
  assign commit  = meas_ok & cand_valid & (cand_idx == cls.idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q       <= 1'b0;
      fs_qq      <= 1'b0;
      have_prev  <= 1'b0;
      cnt        <= '0;
      cand_valid <= 1'b0;
      cand_idx   <= '0;
      ratio_idx  <= '0;
      locked     <= 1'b0;
    end else begin
      fs_q  <= fsync;
      fs_qq <= fs_q;
      if (fs_rise) begin
        cnt       <= '0;
        have_prev <= 1'b1;
        if (have_prev) begin
          cand_valid <= cls.hit;
          cand_idx   <= cls.idx;
        end
        if (commit) begin
          ratio_idx <= cls.idx;
          locked    <= 1'b1;
        end
      end else if (cnt != '1) begin
        cnt <= cnt + len_t'(1);
      end
    end
  end
endmodule

// File: rtl/mclk_tick_gen.sv
module mclk_tick_gen
  import mclk_prescaler_pkg::*;
#(
  parameter int TICKS_PER_FRAME = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_rise,
  input  logic active,
  input  len_t n_len,
  output logic tick,
  output logic strobe
);
  localparam int SW = LEN_W + 1;
  localparam int TW = $clog2(TICKS_PER_FRAME);

  len_t          acc, base;
  logic [SW-1:0] sum;
  logic          due;
  logic [TW-1:0] tk, tk_base;

  assign base    = fs_rise ? '0 : acc;
  assign sum     = {1'b0, base} + SW'(TICKS_PER_FRAME);
  assign due     = sum >= {1'b0, n_len};
  assign tick    = active & due;
  assign tk_base = fs_rise ? '0 : tk;
  assign strobe  = tick & (tk_base == TW'(TICKS_PER_FRAME - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      tk  <= '0;
    end else begin
      acc <= due ? len_t'(sum - {1'b0, n_len}) : sum[LEN_W-1:0];
      tk  <= tk_base + TW'(tick);
    end
  end
endmodule

// File: rtl/mclk_power_ctl.sv
module mclk_power_ctl
  import mclk_prescaler_pkg::*;
#(
  parameter int SYNC_MARGIN = 8,
  parameter int WAKE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  input  logic fs_rise,
  input  len_t cnt,
  input  len_t n_lim,
  output logic pwr_q,
  output logic timeout,
  output logic standby,
  output logic tx_permit
);
  localparam int SW = LEN_W + 1;
  localparam int WW = $clog2(WAKE_FRAMES + 1);

  logic [SW-1:0] lim;
  logic [WW-1:0] wake;

  assign lim       = {1'b0, n_lim} + SW'(SYNC_MARGIN);
  assign timeout   = ~fs_rise & ({1'b0, cnt} > lim);
  assign tx_permit = ~standby & (wake == WW'(WAKE_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      standby <= 1'b1;
      wake    <= '0;
    end else begin
      pwr_q <= pwr_up;
      if (!pwr_q || timeout)      standby <= 1'b1;
      else if (standby && fs_rise) standby <= 1'b0;
      if (standby)                                     wake <= '0;
      else if (fs_rise && wake != WW'(WAKE_FRAMES))    wake <= wake + WW'(1);
    end
  end
endmodule

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
  import mclk_prescaler_pkg::*;
#(
  parameter int TICKS_PER_FRAME = 32,
  parameter int SYNC_MARGIN     = 8,
  parameter int MATCH_TOL       = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic pwr_up,
  output logic tick_256k,
  output logic tick_8k,
  output logic standby,
  output logic tx_permit
);
  logic fs_rise, commit, locked, sync_timeout, pwr_q, active;
  len_t cnt, n_len, n_lim;
  idx_t ratio_idx;

  mclk_frame_meter #(.MATCH_TOL(MATCH_TOL)) u_meter (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .fs_rise(fs_rise),
    .cnt(cnt), .commit(commit), .ratio_idx(ratio_idx), .locked(locked)
  );

  assign n_len  = rate_len(ratio_idx);
  assign n_lim  = locked ? n_len : rate_len(idx_t'(RATE_N - 1));
  assign active = locked & ~standby;

  mclk_tick_gen #(.TICKS_PER_FRAME(TICKS_PER_FRAME)) u_ticks (
    .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .active(active),
    .n_len(n_len), .tick(tick_256k), .strobe(tick_8k)
  );

  mclk_power_ctl #(.SYNC_MARGIN(SYNC_MARGIN), .WAKE_FRAMES(2)) u_power (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .fs_rise(fs_rise),
    .cnt(cnt), .n_lim(n_lim), .pwr_q(pwr_q), .timeout(sync_timeout),
    .standby(standby), .tx_permit(tx_permit)
  );
endmodule

// File: rtl/mclk_prescaler_chk.sv
module mclk_prescaler_chk
  import mclk_prescaler_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic fs_rise,
  input logic commit,
  input logic sync_timeout,
  input logic pwr_q,
  input idx_t ratio_idx,
  input logic tick_256k,
  input logic tick_8k,
  input logic standby,
  input logic tx_permit
);
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_8k |-> tick_256k); // R5
  AST_RATIO_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ratio_idx) |-> $past(fs_rise) && $past(commit)); // R2
  AST_TIMEOUT_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_timeout |=> standby); // R6
  AST_PWR_LOW_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> standby); // R7
  AST_WAKE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(fs_rise) && $past(pwr_q)); // R8
  AST_PERMIT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> $past(fs_rise)); // R9
  AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !tick_256k && !tx_permit); // R10
endmodule

bind mclk_prescaler mclk_prescaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .commit(commit),
  .sync_timeout(sync_timeout), .pwr_q(pwr_q), .ratio_idx(ratio_idx),
  .tick_256k(tick_256k), .tick_8k(tick_8k), .standby(standby),
  .tx_permit(tx_permit)
);

// File: tb/mclk_prescaler_tb.sv
module mclk_prescaler_tb;
  logic clk = 1'b0;
  logic rst_n, fsync, pwr_up;
  logic tick_256k, tick_8k, standby, tx_permit;

  always #4 clk = ~clk;

  mclk_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .pwr_up(pwr_up),
    .tick_256k(tick_256k), .tick_8k(tick_8k), .standby(standby),
    .tx_permit(tx_permit)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t256, t8, last_tick, gmin, gmax;
  int lens[8] = '{32, 64, 192, 193, 256, 320, 512, 600};

  always @(negedge clk) begin
    cyc++;
    if (tick_256k) begin
      t256++;
      if (last_tick >= 0) begin
        if (cyc - last_tick < gmin) gmin = cyc - last_tick;
        if (cyc - last_tick > gmax) gmax = cyc - last_tick;
      end
      last_tick = cyc;
    end
    if (tick_8k) t8++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    t256 = 0; t8 = 0; last_tick = -1; gmin = 1000000; gmax = 0;
  endtask

  task automatic frame(input int n);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_ticks(input int f, input int n);
    return (32 * f) / n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fsync = 1'b0; pwr_up = 1'b1;
    clear_stats();
    wait_cyc(5);
    // R1: reset state
    chk(standby == 1'b1, "R1 standby", standby, 1);
    chk(tx_permit == 1'b0, "R1 permit", tx_permit, 0);
    chk(t256 == 0 && t8 == 0, "R1 ticks", t256 + t8, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(standby == 1'b1 && tx_permit == 1'b0, "R1 after release", standby, 1);

    // R10: no ticks before a ratio is committed
    clear_stats();
    frame(64); frame(64);
    chk(t256 == 0, "R10 unlocked ticks", t256, 0);

    // R4 / R5 / R2: sweep all eight frame lengths
    for (int i = 0; i < 8; i++) begin
      repeat (6) frame(lens[i]);
      clear_stats();
      repeat (4) frame(lens[i]);
      chk(t256 == 128, $sformatf("R4 ticks len=%0d", lens[i]), t256, 128);
      chk(t8 == 4, $sformatf("R5 strobes len=%0d", lens[i]), t8, 4);
      chk(gmin >= lens[i] / 32, $sformatf("R4 min gap len=%0d", lens[i]), gmin, lens[i] / 32);
      chk(gmax <= (lens[i] + 31) / 32, $sformatf("R4 max gap len=%0d", lens[i]), gmax, (lens[i] + 31) / 32);
      chk(tx_permit == 1'b1, $sformatf("R9 permit len=%0d", lens[i]), tx_permit, 1);
    end

    // R2: 257-cycle frames match the 256 entry
    repeat (6) frame(257);
    clear_stats();
    repeat (4) frame(257);
    chk(t256 == 4 * exp_ticks(257, 256), "R2 tol 257->256 ticks", t256, 4 * exp_ticks(257, 256));
    chk(t8 == 4, "R2 tol 257->256 strobes", t8, 4);

    // R3: unknown 100-cycle frames keep the 256 ratio
    repeat (3) frame(100);
    clear_stats();
    repeat (4) frame(100);
    chk(t256 == 4 * exp_ticks(100, 256), "R3 unknown len ticks", t256, 4 * exp_ticks(100, 256));
    chk(t8 == 0, "R3 unknown len strobes", t8, 0);

    // R6: sync-loss timeout with N=256
    repeat (4) frame(256);
    wait_cyc(4);
    chk(standby == 1'b0, "R6 awake inside window", standby, 0);
    wait_cyc(12);
    chk(standby == 1'b1, "R6 standby after timeout", standby, 1);
    clear_stats();
    wait_cyc(50);
    chk(t256 == 0, "R10 no ticks in standby", t256, 0);

    // R10: ticks resume at once after waking (ratio kept)
    frame(256);
    clear_stats();
    repeat (2) frame(256);
    chk(t256 == 64, "R10 ratio kept through standby", t256, 64);

    // R7: power request low forces standby
    frame(256);
    pwr_up = 1'b0;
    wait_cyc(3);
    chk(standby == 1'b1, "R7 pwr low standby", standby, 1);
    clear_stats();
    repeat (3) frame(256);
    chk(standby == 1'b1, "R7 stays with sync running", standby, 1);
    chk(t256 == 0 && tx_permit == 1'b0, "R8 no wake while pwr low", t256, 0);

    // R8: pwr high without sync edges stays asleep
    pwr_up = 1'b1;
    wait_cyc(40);
    chk(standby == 1'b1, "R8 no wake without sync", standby, 1);

    // R9: permit two frames after the waking edge
    frame(256);
    chk(standby == 1'b0, "R8 woke on sync edge", standby, 0);
    chk(tx_permit == 1'b0, "R9 permit after wake edge", tx_permit, 0);
    frame(256);
    chk(tx_permit == 1'b0, "R9 permit after one frame", tx_permit, 0);
    frame(256);
    chk(tx_permit == 1'b1, "R9 permit after two frames", tx_permit, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule